// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block stores incoming packets in system memory under the control of a ring of descriptors. When a packet starts arriving and the receiver is enabled, the engine fetches the descriptor at the current ring position. If the descriptor is armed, the engine streams the packet bytes into the buffer that the descriptor names. Bytes beyond a programmable length limit are consumed and thrown away. The engine then overwrites the descriptor's control word with the result and moves on to the next ring slot.

The ring occupies one naturally aligned area of `NDESC` slots of 8 bytes each. Word 0 of a slot is control/status and word 1 is the buffer address. The ring position wraps to slot 0 after the last slot, or earlier after any slot whose wrap flag is set. Software may place the ring position anywhere while the engine is idle. Memory traffic uses a single word-wide request/acknowledge master. A request stays asserted and unchanged until it is acknowledged, and read data is taken in the acknowledge cycle.

Top module: `rx_desc_dma`

## Requirements
- R1: With `rx_en` high and `pkt_valid` high while idle, the first memory access is a read of control word 0 at `{tbl_base[31:10], cur_sel, 3'b000}`. `rx_active` stays high until the status write completes.
- R2: If the control word read shows bit 25 (armed) clear, `pkt_ready` stays low, no data is written, and the same slot is read again. Once the slot is armed, the packet is received normally.
- R3: If `rx_en` is low when an unarmed slot is read, the engine returns to idle with `rx_active` low and `cur_sel` unchanged.
- R4: Packet byte i is written to buffer address + i. It goes into lane i mod 4 of the word (little-endian), and the byte enables cover only the valid bytes.
- R5: At most `max_len` bytes are stored, and bytes beyond that leave memory untouched. Bits 24:0 of the written-back status equal the number of bytes stored.
- R6: Status bit 31 is set exactly when the packet had more than `max_len` bytes.
- R7: The status write goes to control word 0 of the same slot, with all byte enables set. It has bit 25 clear, keeps the slot's wrap bit 26, and is the last access of the packet.
- R8: After the status write, `cur_sel` advances by one. It goes from `NDESC-1` (127) to 0.
- R9: After a slot whose wrap bit 26 is set, `cur_sel` becomes 0.
- R10: A `sel_load` pulse while idle sets `cur_sel` to `sel_init`, and the next packet uses that slot.
- R11: After reset, `rx_active`, `mem_req` and `pkt_ready` are low and `cur_sel` is 0.
- R12: While `mem_req` is high and `mem_ack` is low, the request, its address and its direction are held on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| max_len | input | 25 | Byte limit per packet (multiple of 4, nonzero) |
| tbl_base | input | 32 | Ring base address (bits 9:0 ignored) |
| sel_load | input | 1 | Load `sel_init` into the ring position (idle only) |
| sel_init | input | 7 | Ring position to load |
| pkt_valid | input | 1 | Packet byte valid |
| pkt_data | input | 8 | Packet byte |
| pkt_eop | input | 1 | Marks last byte of a packet |
| pkt_ready | output | 1 | Byte accepted when high together with `pkt_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| rx_active | output | 1 | Engine is handling a packet |
| cur_sel | output | 7 | Current ring position |

## Verification
Two things can happen on the same accepted byte: the end of the packet and the completion of a full data word (or the crossing of the length limit). The flush write and the status write-back then have to follow each other without losing or repeating a word. This is provoked by packets whose length is exactly a multiple of four and equal to `max_len`, and by packets one byte over the limit. The bench judges the results from the stored bytes, the untouched sentinel byte after them, the length and truncation fields, and the next ring position. The ring position can also be pushed past its last slot and across a wrap flag in one advance, and those cases are checked from `cur_sel`.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // control/status word 0 field positions
  localparam int ARM_BIT   = 25;
  localparam int WRAP_BIT  = 26;
  localparam int TRUNC_BIT = 31;
  localparam int CNT_BITS  = 25;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTL,
    ST_RD_BUF,
    ST_DATA,
    ST_WR_DAT,
    ST_WR_STS
  } rx_state_e;

  // status word written back after the packet: armed bit cleared
  function automatic logic [31:0] status_word(input logic trunc, input logic wrap,
                                              input logic [CNT_BITS-1:0] cnt);
    logic [31:0] w;
    w = '0;
    w[CNT_BITS-1:0] = cnt;
    w[WRAP_BIT]     = wrap;
    w[ARM_BIT]      = 1'b0;
    w[TRUNC_BIT]    = trunc;
    return w;
  endfunction
endpackage

// File: rtl/rxd_sel.sv
module rxd_sel #(
  parameter int NDESC = 128,
  parameter int SEL_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_val,
  input  logic             adv,
  input  logic             wrap,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NDESC - 1);

  function automatic logic [SEL_W-1:0] next_sel(input logic [SEL_W-1:0] cur, input logic wr);
    if (wr || cur == LAST) return '0;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= '0;
    else if (load) sel <= load_val;
    else if (adv)  sel <= next_sel(sel, wrap);
  end
endmodule

// File: rtl/rxd_pack.sv
module rxd_pack #(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       din,
  input  logic             eop,
  input  logic [LEN_W-1:0] max_len,
  input  logic             drain,
  output logic             wr_pend,
  output logic [31:0]      word,
  output logic [3:0]       be,
  output logic [LEN_W-3:0] word_idx,
  output logic [LEN_W-1:0] stored,
  output logic             trunc,
  output logic             eop_seen
);
  logic       full;
  logic [1:0] lane;
  logic       room;

  assign lane    = stored[1:0];
  assign room    = stored < max_len;
  assign wr_pend = full || (eop_seen && (|be));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0; be <= '0; full <= 1'b0; word_idx <= '0;
      stored <= '0; trunc <= 1'b0; eop_seen <= 1'b0;
    end else if (clr) begin
      be <= '0; full <= 1'b0; word_idx <= '0;
      stored <= '0; trunc <= 1'b0; eop_seen <= 1'b0;
    end else if (drain) begin
      be       <= '0;
      full     <= 1'b0;
      word_idx <= word_idx + 1'b1;
    end else if (take) begin
      eop_seen <= eop;
      if (room) begin
        word[{lane, 3'b000} +: 8] <= din;
        be[lane] <= 1'b1;
        stored   <= stored + 1'b1;
        if (lane == 2'd3) full <= 1'b1;
      end else begin
        trunc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int ADDR_W = 32,
  parameter int NDESC  = 128,
  parameter int LEN_W  = 25,
  parameter int SEL_W  = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              sel_load,
  input  logic [SEL_W-1:0]  sel_init,
  input  logic              pkt_valid,
  input  logic [7:0]        pkt_data,
  input  logic              pkt_eop,
  output logic              pkt_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              rx_active,
  output logic [SEL_W-1:0]  cur_sel
);
  import rxd_pkg::*;

  localparam int TBL_LSB = SEL_W + 3;

  rx_state_e         st;
  logic [ADDR_W-1:0] buf_q;
  logic              wrap_q;
  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] dat_addr;

  // named events for the checker
  logic desc_rd_ev, sts_wr_ev, dat_wr_ev, sel_adv_ev, sel_load_ev, take_ev;

  logic             wr_pend, trunc, eop_seen;
  logic [31:0]      word;
  logic [3:0]       be;
  logic [LEN_W-3:0] word_idx;
  logic [LEN_W-1:0] stored;
  logic             unused_bits;

  assign unused_bits = ^{tbl_base[TBL_LSB-1:0]};

  assign desc_rd_ev  = (st == ST_RD_CTL) && mem_ack;
  assign sts_wr_ev   = (st == ST_WR_STS) && mem_ack;
  assign dat_wr_ev   = (st == ST_WR_DAT) && mem_ack;
  assign sel_adv_ev  = sts_wr_ev;
  assign sel_load_ev = sel_load && (st == ST_IDLE);
  assign take_ev     = pkt_valid && pkt_ready;

  assign desc_addr = {tbl_base[ADDR_W-1:TBL_LSB], cur_sel, 3'b000};
  assign dat_addr  = buf_q + ADDR_W'({word_idx, 2'b00});

  assign rx_active = (st != ST_IDLE);
  assign pkt_ready = (st == ST_DATA) && !wr_pend && !eop_seen;

  rxd_sel #(.NDESC(NDESC), .SEL_W(SEL_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sel_load_ev),
    .load_val (sel_init),
    .adv      (sel_adv_ev),
    .wrap     (wrap_q),
    .sel      (cur_sel)
  );

  rxd_pack #(.LEN_W(LEN_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st == ST_IDLE),
    .take     (take_ev),
    .din      (pkt_data),
    .eop      (pkt_eop),
    .max_len  (max_len),
    .drain    (dat_wr_ev),
    .wr_pend  (wr_pend),
    .word     (word),
    .be       (be),
    .word_idx (word_idx),
    .stored   (stored),
    .trunc    (trunc),
    .eop_seen (eop_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      buf_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:
          if (rx_en && pkt_valid && !sel_load) st <= ST_RD_CTL;
        ST_RD_CTL:
          if (mem_ack) begin
            if (mem_rdata[ARM_BIT]) begin
              wrap_q <= mem_rdata[WRAP_BIT];
              st     <= ST_RD_BUF;
            end else if (!rx_en) begin
              st <= ST_IDLE;
            end
          end
        ST_RD_BUF:
          if (mem_ack) begin
            buf_q <= mem_rdata;
            st    <= ST_DATA;
          end
        ST_DATA:
          if (wr_pend)       st <= ST_WR_DAT;
          else if (eop_seen) st <= ST_WR_STS;
        ST_WR_DAT:
          if (mem_ack) st <= ST_DATA;
        ST_WR_STS:
          if (mem_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'h0;
    mem_wdata = '0;
    case (st)
      ST_RD_CTL: mem_req = 1'b1;
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(4);
      end
      ST_WR_DAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dat_addr;
        mem_be    = be;
        mem_wdata = word;
      end
      ST_WR_STS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = status_word(trunc, wrap_q, CNT_BITS'(stored));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 7,
  parameter int LEN_W   = 25,
  parameter int TBL_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_ready,
  input logic              rx_active,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       mem_rdata,
  input logic [ADDR_W-1:0] tbl_base,
  input logic [LEN_W-1:0]  max_len,
  input logic [SEL_W-1:0]  sel,
  input logic              desc_rd_ev,
  input logic              sts_wr_ev,
  input logic              sel_adv_ev,
  input logic              sel_load_ev,
  input logic              desc_wrap
);
  p_ready_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> rx_active);

  p_stall_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_rd_ev && !mem_rdata[25]) |=> !mem_we);

  p_idle_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |-> !mem_req);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_desc_in_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_ev |-> (mem_addr[ADDR_W-1:TBL_LSB] == tbl_base[ADDR_W-1:TBL_LSB]) && !mem_we);

  p_sts_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_ev |-> (!mem_wdata[25] && mem_be == 4'hF && mem_addr[2:0] == 3'b000));

  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_ev |-> (mem_wdata[LEN_W-1:0] <= max_len));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_adv_ev && !sel_load_ev) |=> $stable(sel));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_adv_ev && desc_wrap) |=> (sel == '0));
endmodule

bind rx_desc_dma rxd_checker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LEN_W(LEN_W), .TBL_LSB(TBL_LSB)
) u_rxd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_ready   (pkt_ready),
  .rx_active   (rx_active),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_wdata   (mem_wdata),
  .mem_rdata   (mem_rdata),
  .tbl_base    (tbl_base),
  .max_len     (max_len),
  .sel         (cur_sel),
  .desc_rd_ev  (desc_rd_ev),
  .sts_wr_ev   (sts_wr_ev),
  .sel_adv_ev  (sel_adv_ev),
  .sel_load_ev (sel_load_ev),
  .desc_wrap   (wrap_q)
);

// File: tb/rx_desc_dma_bench.sv
module rx_desc_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [24:0] max_len = 25'd8;
  logic [31:0] tbl_base = 32'h0;
  logic        sel_load = 1'b0;
  logic [6:0]  sel_init = '0;
  logic        pkt_valid = 1'b0;
  logic [7:0]  pkt_data = '0;
  logic        pkt_eop = 1'b0;
  logic        pkt_ready, mem_req, mem_we, rx_active;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [6:0]  cur_sel;

  always #4 clk = ~clk;

  rx_desc_dma u_rx_desc_dma (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .max_len(max_len), .tbl_base(tbl_base),
    .sel_load(sel_load), .sel_init(sel_init), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_eop(pkt_eop), .pkt_ready(pkt_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rx_active(rx_active), .cur_sel(cur_sel)
  );

  // memory model: 4 KiB, one-cycle acknowledge
  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0;
  int dat_wr_cnt = 0, hold_viol = 0;
  logic [31:0] first_rd = '0;
  logic rd_armed = 1'b0;
  logic prev_hold = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        if (mem_addr >= 32'h400) dat_wr_cnt++;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (rd_armed) begin first_rd <= mem_addr; rd_armed <= 1'b0; end
      end
    end else mem_ack <= 1'b0;
  end

  // R12 monitor: pending request must be held
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_hold && (!mem_req || mem_addr != prev_addr)) hold_viol++;
      prev_hold <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
    end
  end

  typedef struct packed { logic [15:0] n; logic [15:0] mx; } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd1, 16'd4}, '{16'd4, 16'd8}, '{16'd8, 16'd8}, '{16'd9, 16'd8},
    '{16'd3, 16'd4}, '{16'd20, 16'd12}, '{16'd7, 16'd100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 16 + i + 1) & 8'hFF);
  endfunction

  function automatic logic [7:0] mbyte(input int addr);
    logic [31:0] w;
    w = mem[addr >> 2];
    return w[(addr % 4) * 8 +: 8];
  endfunction

  task automatic put_desc(input int s, input logic arm, input logic wrap, input logic [31:0] b);
    mem[s * 2]     = {5'b0, wrap, arm, 25'b0};
    mem[s * 2 + 1] = b;
  endtask

  task automatic fill_buf(input logic [31:0] b);
    for (int w = 0; w < 16; w++) mem[(b >> 2) + w] = 32'hEEEEEEEE;
  endtask

  task automatic send_pkt(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pkt_valid = 1'b1; pkt_data = pbyte(seed, i); pkt_eop = (i == n - 1);
      while (!pkt_ready) @(negedge clk);
    end
    @(negedge clk);
    pkt_valid = 1'b0; pkt_eop = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (rx_active && t < 500) begin @(negedge clk); t++; end
  endtask

  task automatic load_sel(input logic [6:0] v);
    @(negedge clk); sel_load = 1'b1; sel_init = v;
    @(negedge clk); sel_load = 1'b0;
  endtask

  // check stored bytes, sentinel, status word of one packet
  task automatic judge(input string tag, input int s, input logic [31:0] b, input int n,
                       input int mx, input int seed, input logic wrap);
    int stored, bad;
    logic [31:0] st;
    stored = (n < mx) ? n : mx;
    bad = 0;
    for (int i = 0; i < stored; i++) if (mbyte(b + i) !== pbyte(seed, i)) bad++;
    chk({tag, " R4 data bytes"}, bad, 0);
    chk({tag, " R5 byte after stored untouched"}, {24'b0, mbyte(b + stored)}, 32'hEE);
    st = mem[s * 2];
    chk({tag, " R5 length field"}, {7'b0, st[24:0]}, stored);
    chk({tag, " R6 truncation flag"}, {31'b0, st[31]}, {31'b0, n > mx});
    chk({tag, " R7 armed bit cleared, wrap kept"}, {30'b0, st[26:25]}, {30'b0, wrap, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base_wr;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rx_active after reset", {31'b0, rx_active}, 0);
    chk("R11 mem_req after reset", {31'b0, mem_req}, 0);
    chk("R11 pkt_ready after reset", {31'b0, pkt_ready}, 0);
    chk("R11 cur_sel after reset", {25'b0, cur_sel}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;

    // vector walk: slots 0..6
    for (int k = 0; k < NV; k++) begin
      logic [31:0] b;
      b = 32'h400 + k * 32'h40;
      fill_buf(b);
      put_desc(k, 1'b1, 1'b0, b);
      max_len = 25'(VECS[k].mx);
      rd_armed = 1'b1;
      send_pkt(int'(VECS[k].n), k);
      wait_idle();
      chk($sformatf("v%0d R1 descriptor address", k), first_rd, k * 8);
      judge($sformatf("v%0d", k), k, b, int'(VECS[k].n), int'(VECS[k].mx), k, 1'b0);
      chk($sformatf("v%0d R8 selector advance", k), {25'b0, cur_sel}, k + 1);
    end

    // R2: unarmed slot 7 stalls, then proceeds once armed
    max_len = 25'd16;
    fill_buf(32'h800);
    put_desc(7, 1'b0, 1'b0, 32'h800);
    base_wr = dat_wr_cnt;
    fork send_pkt(6, 9); join_none
    repeat (30) @(negedge clk);
    chk("R2 rx_active while polling", {31'b0, rx_active}, 1);
    chk("R2 pkt_ready low while polling", {31'b0, pkt_ready}, 0);
    chk("R2 no data writes while polling", dat_wr_cnt - base_wr, 0);
    put_desc(7, 1'b1, 1'b0, 32'h800);
    wait fork;
    wait_idle();
    judge("poll", 7, 32'h800, 6, 16, 9, 1'b0);
    chk("R2 selector after poll", {25'b0, cur_sel}, 8);

    // R3: disable while polling slot 8
    put_desc(8, 1'b0, 1'b0, 32'h840);
    @(negedge clk); pkt_valid = 1'b1; pkt_data = 8'h55; pkt_eop = 1'b1;
    repeat (20) @(negedge clk);
    rx_en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 rx_active after disable", {31'b0, rx_active}, 0);
    chk("R3 selector unchanged", {25'b0, cur_sel}, 8);
    pkt_valid = 1'b0; pkt_eop = 1'b0;
    @(negedge clk); rx_en = 1'b1;

    // R9: wrap flag on slot 8, limit crossed on the same packet
    max_len = 25'd4;
    fill_buf(32'h840);
    put_desc(8, 1'b1, 1'b1, 32'h840);
    send_pkt(5, 3);
    wait_idle();
    judge("wrapflag", 8, 32'h840, 5, 4, 3, 1'b1);
    chk("R9 selector after wrap flag", {25'b0, cur_sel}, 0);

    // R10 + R8: load last slot, natural wrap to 0
    load_sel(7'd127);
    chk("R10 selector loaded", {25'b0, cur_sel}, 127);
    max_len = 25'd8;
    fill_buf(32'h880);
    put_desc(127, 1'b1, 1'b0, 32'h880);
    rd_armed = 1'b1;
    send_pkt(8, 5);
    wait_idle();
    chk("R10 descriptor read at loaded slot", first_rd, 127 * 8);
    judge("last", 127, 32'h880, 8, 8, 5, 1'b0);
    chk("R8 selector wraps from last slot", {25'b0, cur_sel}, 0);

    // R10: mid-table start
    load_sel(7'd10);
    fill_buf(32'h8C0);
    put_desc(10, 1'b1, 1'b0, 32'h8C0);
    rd_armed = 1'b1;
    send_pkt(2, 6);
    wait_idle();
    chk("R10 mid-table descriptor address", first_rd, 80);
    judge("mid", 10, 32'h8C0, 2, 8, 6, 1'b0);
    chk("R10 selector after mid-table packet", {25'b0, cur_sel}, 11);

    chk("R12 request held until acknowledge", hold_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule